// File: doc/BRIEF.md
# Transmit Queue Space and Completion Status Controller

This block supervises the transmit side of a packet FIFO that the host fills with 32-bit writes. It holds the bookkeeping for the FIFO but not the data. It counts the free bytes and follows packet framing. Each packet starts with a length dword, followed by the payload rounded up to whole dwords. The block tells the medium transmitter when enough bytes are queued to begin sending. A host command arms an event that fires once free space has grown to a programmed level. The block also keeps a small stack of per-frame completion status bytes. The host reads the top entry and pops it.

The transmitter pulls bytes with a single-byte strobe and reports the end of each frame with error flags. An underrun is a byte request that arrives while the queue is empty and the current frame has not been fully written. An underrun or a jabber halts the transmitter until software issues a transmit reset.

Top module: `txq_ctrl`

## Requirements
- R1: After reset, or after a transmit-reset command (code 5), the block is in its idle state. The free count equals FIFO_BYTES, the status stack is empty, the transmitter is disabled and not halted, and both thresholds are zero with the available event disarmed.
- R2: A host write accepted while at least 4 bytes are free lowers the free count by 4. A host write made while fewer than 4 bytes are free is ignored and leaves the free count unchanged.
- R3: When no frame is open, an accepted write is a length word. Its low LEN_W bits give the frame length L. The frame is then open for ceil(L/4) further accepted writes. A byte request from the transmitter is an underrun only while a frame is open.
- R4: Command code 1 sets the available threshold to cmd_arg and arms the event. While the event is armed, tx_avail_evt pulses high for exactly one cycle, one clock after the registered free count is at least the threshold. The event is then disarmed.
- R5: Command code 2 sets the start threshold. tx_go is high exactly when the transmitter is enabled, not halted, and the queued byte count (FIFO_BYTES minus free) is nonzero and at least the start threshold.
- R6: A byte_take strobe while the transmitter runs and the queue is not empty raises the free count by 1. The queued count includes the length word.
- R7: frame_done pushes a status byte with bit 7 (0x80) set. It also sets 0x08 for frame_maxcoll, 0x20 for frame_jabber and 0x40 for frame_intreq.
- R8: An underrun pushes the status byte 0x90 (complete plus underrun bit 0x10).
- R9: stat_byte shows the newest stack entry, or 0 when the stack is empty. stat_pop removes the newest entry, and a pop of an empty stack has no effect. stat_pending is high while entries remain.
- R10: A push onto a full stack of STACK_DEPTH entries stores nothing new. Instead it sets bit 0x04 in the newest entry.
- R11: A pushed status with the underrun or jabber bit disables and halts the transmitter. A transmit-enable command (code 3) is ignored while halted, and only a transmit reset clears the halt.
- R12: Command code 3 enables the transmitter and code 4 disables it. While disabled, byte_take has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host dword write strobe |
| host_len | input | LEN_W | Low bits of the written dword (length field when it is a length word) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | CW | Command byte-count argument |
| byte_take | input | 1 | Transmitter requests one byte |
| frame_done | input | 1 | Transmitter finished a frame |
| frame_maxcoll | input | 1 | Frame hit the collision limit |
| frame_jabber | input | 1 | Frame ended by jabber |
| frame_intreq | input | 1 | Frame asked for an interrupt |
| stat_pop | input | 1 | Pop the newest status byte |
| free_bytes | output | CW | Free byte count |
| tx_avail_evt | output | 1 | One-cycle available-space event |
| tx_go | output | 1 | Transmitter may send |
| tx_enabled | output | 1 | Transmitter enabled |
| stat_byte | output | 8 | Newest status byte or 0 |
| stat_pending | output | 1 | Status stack not empty |

## Verification
The bench builds the block with FIFO_BYTES=64, LEN_W=12 and STACK_DEPTH=4. With these values the whole FIFO fills in sixteen writes, so every free-count step from empty to full can be checked, including the ignored write at zero. Every start threshold from 4 to 20 bytes is swept against each queue depth it can meet. A fifth push reaches the full-stack overflow marking, and the shallow queue lets a full drain end in an underrun within a few dozen cycles.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_SET_AVAIL = 3'd1,
        CMD_SET_START = 3'd2,
        CMD_TX_ENABLE = 3'd3,
        CMD_TX_OFF    = 3'd4,
        CMD_TX_RESET  = 3'd5
    } txq_cmd_e;

    localparam logic [7:0] ST_OVF  = 8'h04;
    localparam logic [7:0] ST_MCOL = 8'h08;
    localparam logic [7:0] ST_UNDR = 8'h10;
    localparam logic [7:0] ST_JAB  = 8'h20;
    localparam logic [7:0] ST_INT  = 8'h40;
    localparam logic [7:0] ST_DONE = 8'h80;
endpackage

// File: rtl/txq_space.sv
module txq_space #(
    parameter int FIFO_BYTES = 2048,
    parameter int LEN_W      = 16,
    localparam int CW        = $clog2(FIFO_BYTES + 1),
    localparam int WL_W      = LEN_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             take,
    output logic [CW-1:0]    free_o,
    output logic             mid_frame_o
);
    typedef struct packed {
        logic [CW-1:0]   free;
        logic [WL_W-1:0] left;
    } space_t;

    space_t st_q, st_d;
    logic   wr_ok;
    logic [LEN_W:0] padded;

    always_comb begin
        st_d   = st_q;
        wr_ok  = wr_en && (st_q.free >= CW'(4));
        padded = {1'b0, wr_len} + (LEN_W + 1)'(3);
        if (clr) begin
            st_d.free = CW'(FIFO_BYTES);
            st_d.left = '0;
        end else begin
            if (wr_ok) begin
                st_d.free = st_d.free - CW'(4);
                if (st_q.left == '0) st_d.left = padded[LEN_W:2];
                else                 st_d.left = st_q.left - WL_W'(1);
            end
            if (take) st_d.free = st_d.free + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.free <= CW'(FIFO_BYTES);
            st_q.left <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign free_o      = st_q.free;
    assign mid_frame_o = (st_q.left != '0);

    assert_free_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        free_o <= CW'(FIFO_BYTES));

    assert_short_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && free_o < CW'(4) && !take && !clr) |=> free_o == $past(free_o));
endmodule

// File: rtl/txq_stat_stack.sv
module txq_stat_stack
    import txq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       pop,
    output logic [7:0] top_byte,
    output logic       nonempty
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] ent;
        logic [NW-1:0]         cnt;
    } stk_t;

    stk_t stk_q, stk_d;
    logic [NW-1:0] cnt_mid;

    always_comb begin
        stk_d   = stk_q;
        cnt_mid = stk_q.cnt;
        if (pop && stk_q.cnt != '0) cnt_mid = stk_q.cnt - NW'(1);
        stk_d.cnt = cnt_mid;
        if (push) begin
            if (cnt_mid < NW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (NW'(i) == cnt_mid) stk_d.ent[i] = push_byte;
                end
                stk_d.cnt = cnt_mid + NW'(1);
            end else begin
                stk_d.ent[DEPTH-1] = stk_q.ent[DEPTH-1] | ST_OVF;
            end
        end
        if (clr) begin
            stk_d.cnt = '0;
            stk_d.ent = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q.cnt <= '0;
            stk_q.ent <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    always_comb begin
        top_byte = 8'h00;
        for (int i = 0; i < DEPTH; i++) begin
            if (stk_q.cnt != '0 && NW'(i) == stk_q.cnt - NW'(1)) top_byte = stk_q.ent[i];
        end
    end
    assign nonempty = (stk_q.cnt != '0);

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.cnt <= NW'(DEPTH));

    assert_pop_shrinks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && nonempty) |=> stk_q.cnt == $past(stk_q.cnt) - NW'(1));

    assert_full_push_marks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && stk_q.cnt == NW'(DEPTH)) |=>
            (stk_q.cnt == NW'(DEPTH) && top_byte[2]));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int FIFO_BYTES  = 2048,
    parameter int LEN_W       = 16,
    parameter int STACK_DEPTH = 4,
    localparam int CW         = $clog2(FIFO_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [LEN_W-1:0] host_len,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [CW-1:0]    cmd_arg,
    input  logic             byte_take,
    input  logic             frame_done,
    input  logic             frame_maxcoll,
    input  logic             frame_jabber,
    input  logic             frame_intreq,
    input  logic             stat_pop,
    output logic [CW-1:0]    free_bytes,
    output logic             tx_avail_evt,
    output logic             tx_go,
    output logic             tx_enabled,
    output logic [7:0]       stat_byte,
    output logic             stat_pending
);
    typedef struct packed {
        logic          en;
        logic          halt;
        logic          armed;
        logic          evt;
        logic [CW-1:0] avail_thr;
        logic [CW-1:0] start_thr;
    } ctl_t;

    ctl_t     ctl_q, ctl_d;
    txq_cmd_e op;
    logic          clr, running, take, underrun, push, stop, mid_frame;
    logic [7:0]    push_byte;
    logic [CW-1:0] free_w, queued;

    txq_space #(.FIFO_BYTES(FIFO_BYTES), .LEN_W(LEN_W)) space_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(host_wr), .wr_len(host_len),
        .take(take), .free_o(free_w), .mid_frame_o(mid_frame)
    );

    txq_stat_stack #(.DEPTH(STACK_DEPTH)) stack_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .push_byte(push_byte),
        .pop(stat_pop), .top_byte(stat_byte), .nonempty(stat_pending)
    );

    always_comb begin
        op        = cmd_valid ? txq_cmd_e'(cmd_op) : CMD_NOP;
        clr       = (op == CMD_TX_RESET);
        running   = ctl_q.en && !ctl_q.halt;
        queued    = CW'(FIFO_BYTES) - free_w;
        take      = byte_take && running && (queued != '0);
        underrun  = byte_take && running && (queued == '0) && mid_frame;
        push_byte = 8'h00;
        if (frame_done) begin
            push_byte = ST_DONE | (frame_maxcoll ? ST_MCOL : 8'h00)
                      | (frame_jabber ? ST_JAB : 8'h00) | (frame_intreq ? ST_INT : 8'h00);
        end
        if (underrun) push_byte = push_byte | ST_DONE | ST_UNDR;
        push = frame_done || underrun;
        stop = push && ((push_byte & (ST_UNDR | ST_JAB)) != 8'h00);
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.evt = ctl_q.armed && (free_w >= ctl_q.avail_thr);
        if (ctl_d.evt) ctl_d.armed = 1'b0;
        case (op)
            CMD_SET_AVAIL: begin
                ctl_d.avail_thr = cmd_arg;
                ctl_d.armed     = 1'b1;
            end
            CMD_SET_START: ctl_d.start_thr = cmd_arg;
            CMD_TX_ENABLE: if (!ctl_q.halt) ctl_d.en = 1'b1;
            CMD_TX_OFF:    ctl_d.en = 1'b0;
            CMD_TX_RESET:  ctl_d = '0;
            default: ;
        endcase
        if (stop && !clr) begin
            ctl_d.en   = 1'b0;
            ctl_d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign free_bytes   = free_w;
    assign tx_avail_evt = ctl_q.evt;
    assign tx_enabled   = ctl_q.en;
    assign tx_go        = running && (queued != '0) && (queued >= ctl_q.start_thr);

    assert_evt_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_avail_evt |=> !tx_avail_evt);

    assert_underrun_reported_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clr) |=> (stat_pending && !tx_enabled));

    assert_halt_blocks_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.halt && !clr) |=> !tx_enabled);

    assert_go_needs_queue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> (free_bytes != CW'(FIFO_BYTES)));
endmodule

// File: tb/txq_ctrl_tb.sv
`timescale 1ns/1ps
module txq_ctrl_tb_top;
    localparam int FB = 64;
    localparam int LW = 12;
    localparam int SD = 4;
    localparam int CW = $clog2(FB + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr = 0, cmd_valid = 0, byte_take = 0, frame_done = 0;
    logic frame_maxcoll = 0, frame_jabber = 0, frame_intreq = 0, stat_pop = 0;
    logic [LW-1:0] host_len = '0;
    logic [2:0] cmd_op = '0;
    logic [CW-1:0] cmd_arg = '0;
    logic [CW-1:0] free_bytes;
    logic tx_avail_evt, tx_go, tx_enabled, stat_pending;
    logic [7:0] stat_byte;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    txq_ctrl #(.FIFO_BYTES(FB), .LEN_W(LW), .STACK_DEPTH(SD)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_len(host_len),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .byte_take(byte_take), .frame_done(frame_done), .frame_maxcoll(frame_maxcoll),
        .frame_jabber(frame_jabber), .frame_intreq(frame_intreq), .stat_pop(stat_pop),
        .free_bytes(free_bytes), .tx_avail_evt(tx_avail_evt), .tx_go(tx_go),
        .tx_enabled(tx_enabled), .stat_byte(stat_byte), .stat_pending(stat_pending)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(input int op, input int arg);
        cmd_valid = 1; cmd_op = 3'(op); cmd_arg = CW'(arg);
        step();
        cmd_valid = 0; cmd_op = '0; cmd_arg = '0;
    endtask

    task automatic hwr(input int len);
        host_wr = 1; host_len = LW'(len);
        step();
        host_wr = 0; host_len = '0;
    endtask

    task automatic take1();
        byte_take = 1;
        step();
        byte_take = 0;
    endtask

    task automatic fdone(input bit mc, input bit jb, input bit ir);
        frame_done = 1; frame_maxcoll = mc; frame_jabber = jb; frame_intreq = ir;
        step();
        frame_done = 0; frame_maxcoll = 0; frame_jabber = 0; frame_intreq = 0;
    endtask

    task automatic pop1();
        stat_pop = 1;
        step();
        stat_pop = 0;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        // R1 idle state
        chk("R1 free", free_bytes, FB);
        chk("R1 pending", stat_pending, 0);
        chk("R1 stat", stat_byte, 0);
        chk("R1 enabled", tx_enabled, 0);
        chk("R1 go", tx_go, 0);
        chk("R1 evt", tx_avail_evt, 0);

        // R2 fill sweep: length word 60 then 15 payload dwords
        for (int i = 0; i < 16; i++) begin
            hwr(i == 0 ? 60 : 0);
            chk("R2 free after write", free_bytes, FB - 4 * (i + 1));
        end
        hwr(0);
        chk("R2 write at zero ignored", free_bytes, 0);
        cmd(3, 0);
        chk("R12 enable", tx_enabled, 1);
        chk("R5 go full queue", tx_go, 1);
        cmd(5, 0);
        chk("R1 reset free", free_bytes, FB);
        chk("R1 reset enabled", tx_enabled, 0);

        // R5 start threshold sweep
        for (int t = 4; t <= 20; t += 4) begin
            cmd(5, 0); cmd(3, 0); cmd(2, t);
            chk("R5 go empty", tx_go, 0);
            for (int k = 1; k <= 6; k++) begin
                hwr(k == 1 ? 60 : 0);
                chk("R5 go vs threshold", tx_go, (4 * k >= t) ? 1 : 0);
            end
        end
        // queued 24 here; R6 consume
        take1();
        chk("R6 consume frees byte", free_bytes, FB - 24 + 1);
        cmd(4, 0);
        chk("R12 disable", tx_enabled, 0);
        chk("R12 go off", tx_go, 0);
        take1();
        chk("R12 take ignored while off", free_bytes, FB - 23);

        // R3 framing: complete frame then extra request -> no underrun
        cmd(5, 0); cmd(3, 0);
        hwr(4); hwr(0);
        for (int i = 0; i < 8; i++) take1();
        chk("R6 drained", free_bytes, FB);
        take1();
        chk("R3 closed frame no underrun", stat_pending, 0);
        chk("R3 still enabled", tx_enabled, 1);
        // length 5 rounds up to two payload dwords
        cmd(5, 0); cmd(3, 0);
        hwr(5); hwr(0);
        for (int i = 0; i < 8; i++) take1();
        take1();
        chk("R3 rounded frame still open", stat_byte, 8'h90);

        // R4 available event
        cmd(5, 0); cmd(3, 0);
        for (int i = 0; i < 14; i++) hwr(i == 0 ? 60 : 0);
        chk("R4 free before", free_bytes, 8);
        cmd(1, 20);
        step();
        chk("R4 no evt below", tx_avail_evt, 0);
        for (int i = 0; i < 12; i++) begin
            take1();
            chk("R4 evt during drain", tx_avail_evt, 0);
        end
        chk("R4 free at threshold", free_bytes, 20);
        step();
        chk("R4 evt fires", tx_avail_evt, 1);
        step();
        chk("R4 evt one cycle", tx_avail_evt, 0);

        // R8 underrun with frame open
        for (int i = 0; i < 44; i++) take1();
        chk("R6 queue empty", free_bytes, FB);
        chk("R8 no status yet", stat_pending, 0);
        take1();
        chk("R8 underrun status", stat_byte, 8'h90);
        chk("R8 pending", stat_pending, 1);
        chk("R11 halted by underrun", tx_enabled, 0);
        chk("R8 free unchanged", free_bytes, FB);
        cmd(3, 0);
        chk("R11 enable ignored while halted", tx_enabled, 0);
        cmd(5, 0);
        chk("R1 reset clears stack", stat_pending, 0);
        chk("R1 reset stat zero", stat_byte, 0);
        cmd(3, 0);
        chk("R11 enable after reset", tx_enabled, 1);

        // R7, R9, R10 stack
        fdone(1, 0, 0);
        chk("R7 maxcoll", stat_byte, 8'h88);
        fdone(0, 0, 1);
        chk("R7 intreq", stat_byte, 8'hC0);
        fdone(0, 0, 0);
        chk("R7 plain", stat_byte, 8'h80);
        fdone(1, 0, 1);
        chk("R9 newest on top", stat_byte, 8'hC8);
        fdone(0, 0, 0);
        chk("R10 overflow marks newest", stat_byte, 8'hCC);
        pop1(); chk("R9 pop 1", stat_byte, 8'h80);
        pop1(); chk("R9 pop 2", stat_byte, 8'hC0);
        pop1(); chk("R9 pop 3", stat_byte, 8'h88);
        chk("R9 pending with one left", stat_pending, 1);
        pop1(); chk("R9 empty reads zero", stat_byte, 0);
        chk("R9 not pending", stat_pending, 0);
        pop1(); chk("R9 pop empty no effect", stat_byte, 0);
        chk("R11 plain frames keep enabled", tx_enabled, 1);

        fdone(0, 1, 0);
        chk("R7 jabber status", stat_byte, 8'hA0);
        chk("R11 jabber halts", tx_enabled, 0);
        cmd(3, 0);
        chk("R11 enable ignored after jabber", tx_enabled, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule